// File: doc/BRIEF.md
# Panel Pixel Output Formatter

This block sits at the end of a display pipeline. Each clock it takes one processed pixel of three 8-bit components, qualified by a data-enable. It places that pixel onto a 36-lane parallel bus that drives a flat panel. A 3-bit mode input chooses the lane layout:

- **Single-phase modes** carry one pixel per clock, at 24 or 18 bits.
- **Two-phase mode** carries an odd/even pixel pair per output cycle, at half the pixel rate.
- **Decoder modes** carry component colour, either full-rate 4:4:4 or chroma-multiplexed 4:2:2.

The block also produces a pixel clock enable. That enable can be divided by two, and its phase can be inverted.

The input pixel is packed as `{c2, c1, c0}`, each field 8 bits wide:

| Field | RGB meaning | Component meaning |
|-------|-------------|-------------------|
| c0 | red | Cb |
| c1 | green | Y |
| c2 | blue | Cr |

Within every line, the first active pixel counts as pixel 1, which is odd. In two-phase mode, odd pixels wait in a holding register until their even partner arrives. Every output passes through one register stage, and the output data-enable travels with it.

Top module: `pnl_lane_fmt`

## Requirements
- R1: While reset is high, all 36 lanes, the output data-enable and the pixel clock enable are 0.
- R2: Mode 1, 2 or 5 with `depth6`=0 gives single-phase 8-bit output one cycle after the input:
  - lanes 0–7 carry c0, lanes 8–15 carry c2, lanes 16–23 carry c1;
  - lanes 24–35 are 0.
- R3: Mode 1, 2 or 5 with `depth6`=1 gives 6-bit output using bits 7:2 of each component:
  - lanes 0–5 carry c0, lanes 8–13 carry c2, lanes 16–21 carry c1;
  - every other lane is 0.
- R4: Mode 0 (two-phase) holds an odd pixel. On the cycle after its even partner is sampled, it emits the pair for exactly one cycle:
  - the odd pixel's bits 7:2 go to lanes 0–5 (c0), 6–11 (c2) and 12–17 (c1);
  - the even pixel's bits 7:2 go to lanes 18–23 (c0), 24–29 (c2) and 30–35 (c1);
  - the output data-enable is low while an odd pixel is being held.
- R5: In mode 0, an odd pixel left unpaired when the data-enable falls is emitted on the cycle after the first low sample. Its even half (lanes 18–35) is zero. A line with an even count emits nothing extra.
- R6: Mode 3 is 4:4:4 decoder output: Y (c1) on lanes 16–23, Cb (c0) on lanes 0–7, Cr (c2) on lanes 8–15. `depth6` has no effect in this mode.
- R7: Mode 4 is 4:2:2 decoder output:
  - Y (c1) goes on lanes 16–23;
  - lanes 8–15 carry Cb (c0) on odd pixels and Cr (c2) on even pixels, counting from 1 again at the start of each line;
  - lanes 0–7 are 0.
- R8: Codes 6 and 7 are undefined: all lanes are 0, while the output data-enable still follows the input data-enable.
- R9: Whenever the output data-enable is low, all lanes are 0.
- R10: The pixel clock enable behaves as follows:
  - with `pclk_div2`=0 it is 1 after reset;
  - with `pclk_div2`=1 it alternates every cycle;
  - a change of `pclk_inv` shifts its phase by one cycle, so the value repeats once.
- R11: In every mode other than 0, the output data-enable equals the input data-enable of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Lane layout code |
| depth6 | input | 1 | Selects 6-bit output in single-phase modes |
| pclk_div2 | input | 1 | Divides the pixel clock enable by two |
| pclk_inv | input | 1 | Inverts the phase of the divided enable |
| de_in | input | 1 | Input pixel qualifier |
| pix_in | input | 24 | Input pixel `{c2, c1, c0}` |
| out_lanes | output | 36 | Panel bus lanes |
| out_de | output | 1 | Output data-enable, aligned to `out_lanes` |
| pclk_en | output | 1 | Pixel clock enable |

## Verification
The bench checks the boundaries of a line, both in two-phase mode and in 4:2:2 mode:

- A line of odd length must flush its last pixel with the even half zero. A design that forgot the orphan would drop that pixel; one that flushed on every line end would emit a spurious pair.
- The 4:2:2 chroma phase must restart at each line. A design that carried the phase across lines would send Cr where Cb belongs.

The 6-bit layouts are compared in full, so low bits leaking into the unused lanes are caught, as is any confusion between the single-phase and two-phase lane layouts. Undefined codes and idle cycles are checked for all-zero lanes. The enable's phase step after an inversion change is also checked.

// File: rtl/pnl_fmt_pkg.sv
package pnl_fmt_pkg;
  localparam int unsigned COMP_W = 8;   // input component width
  localparam int unsigned NARROW_W = 6; // 6-bit lane field width
  localparam int unsigned BUS_W = 36;   // panel lanes

  localparam logic [2:0] MD_TWO   = 3'd0;
  localparam logic [2:0] MD_SP_A  = 3'd1;
  localparam logic [2:0] MD_SP_B  = 3'd2;
  localparam logic [2:0] MD_DEC44 = 3'd3;
  localparam logic [2:0] MD_DEC22 = 3'd4;
  localparam logic [2:0] MD_SP_C  = 3'd5;

  // lane slot k takes input component slot_src(k): c0, c2, c1
  function automatic int slot_src(input int k);
    return (k == 0) ? 0 : ((k == 1) ? 2 : 1);
  endfunction
endpackage

// File: rtl/pnl_pair_track.sv
module pnl_pair_track #(
  parameter int unsigned PXW = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           de_in,
  input  logic [PXW-1:0] pix_in,
  output logic           ph,      // 1: an odd pixel has been taken
  output logic [PXW-1:0] odd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= 1'b0;
      odd_q <= '0;
    end else if (de_in) begin
      ph <= ~ph;
      if (!ph) odd_q <= pix_in;
    end else begin
      ph <= 1'b0;
    end
  end

  // line parity restarts whenever the qualifier drops
  AST_PARITY_RESTART: assert property (@(posedge clk) disable iff (rst)
    (!de_in && !$past(rst)) |=> !ph);  // R7
endmodule

// File: rtl/pnl_lane_map.sv
module pnl_lane_map
  import pnl_fmt_pkg::*;
#(
  parameter int unsigned CW = COMP_W,
  parameter int unsigned PW = NARROW_W,
  parameter int unsigned LANES = BUS_W
) (
  input  logic [2:0]      mode,
  input  logic            depth6,
  input  logic            de_in,
  input  logic            ph,
  input  logic [3*CW-1:0] cur,
  input  logic [3*CW-1:0] odd,
  output logic [LANES-1:0] lanes,
  output logic            vld
);
  localparam int unsigned NSLOT = 3;

  logic [CW-1:0] c_cur [NSLOT];
  logic [CW-1:0] c_odd [NSLOT];

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam int SRC = slot_src(k);
    assign c_cur[k] = cur[SRC*CW +: CW];
    assign c_odd[k] = odd[SRC*CW +: CW];
  end

  always_comb begin
    lanes = '0;
    vld   = de_in;
    case (mode)
      MD_TWO: begin
        vld = ph;
        for (int k = 0; k < NSLOT; k++) begin
          lanes[k*PW +: PW] = c_odd[k][CW-1 -: PW];
          lanes[(NSLOT+k)*PW +: PW] = de_in ? c_cur[k][CW-1 -: PW] : '0;
        end
      end
      MD_SP_A, MD_SP_B, MD_SP_C: begin
        for (int k = 0; k < NSLOT; k++) begin
          if (depth6) lanes[k*CW +: PW] = c_cur[k][CW-1 -: PW];
          else        lanes[k*CW +: CW] = c_cur[k];
        end
      end
      MD_DEC44: begin
        for (int k = 0; k < NSLOT; k++) lanes[k*CW +: CW] = c_cur[k];
      end
      MD_DEC22: begin
        lanes[2*CW +: CW] = c_cur[2];
        lanes[CW +: CW]   = ph ? c_cur[1] : c_cur[0];
      end
      default: lanes = '0;
    endcase
    if (!vld) lanes = '0;
  end
endmodule

// File: rtl/pnl_clk_en.sv
module pnl_clk_en (
  input  logic clk,
  input  logic rst,
  input  logic div2,
  input  logic inv,
  output logic en_q
);
  logic tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog  <= 1'b0;
      en_q <= 1'b0;
    end else begin
      tog  <= ~tog;
      en_q <= div2 ? (tog ^ inv) : 1'b1;
    end
  end

  AST_HALF_RATE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(div2) && $past(div2, 2)
     && ($past(inv) == $past(inv, 2))) |-> (en_q != $past(en_q)));  // R10
endmodule

// File: rtl/pnl_lane_fmt.sv
module pnl_lane_fmt
  import pnl_fmt_pkg::*;
#(
  parameter int unsigned CW = COMP_W,
  parameter int unsigned PW = NARROW_W,
  parameter int unsigned LANES = BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic             depth6,
  input  logic             pclk_div2,
  input  logic             pclk_inv,
  input  logic             de_in,
  input  logic [3*CW-1:0]  pix_in,
  output logic [LANES-1:0] out_lanes,
  output logic             out_de,
  output logic             pclk_en
);
  logic             ph;
  logic [3*CW-1:0]  odd_q;
  logic [LANES-1:0] map_lanes;
  logic             map_vld;

  pnl_pair_track #(.PXW(3*CW)) u_pair (
    .clk(clk), .rst(rst), .de_in(de_in), .pix_in(pix_in),
    .ph(ph), .odd_q(odd_q)
  );

  pnl_lane_map #(.CW(CW), .PW(PW), .LANES(LANES)) u_map (
    .mode(mode), .depth6(depth6), .de_in(de_in), .ph(ph),
    .cur(pix_in), .odd(odd_q), .lanes(map_lanes), .vld(map_vld)
  );

  pnl_clk_en u_clk (
    .clk(clk), .rst(rst), .div2(pclk_div2), .inv(pclk_inv), .en_q(pclk_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_lanes <= '0;
      out_de    <= 1'b0;
    end else begin
      out_lanes <= map_lanes;
      out_de    <= map_vld;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_de |-> (out_lanes == '0));  // R9
  AST_DE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) != MD_TWO) |-> (out_de == $past(de_in)));  // R11
  AST_UPPER_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) != MD_TWO) |-> (out_lanes[LANES-1:3*CW] == '0));  // R2
  AST_PAIR_GAP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && out_de && mode == MD_TWO && $past(mode) == MD_TWO) |=> !out_de);  // R4
endmodule

// File: tb/pnl_lane_fmt_bench.sv
module pnl_lane_fmt_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode = 3'd1;
  logic        depth6 = 1'b0;
  logic        pclk_div2 = 1'b0;
  logic        pclk_inv = 1'b0;
  logic        de_in = 1'b0;
  logic [23:0] pix_in = '0;
  logic [35:0] out_lanes;
  logic        out_de;
  logic        pclk_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pnl_lane_fmt u_pnl_lane_fmt (
    .clk(clk), .rst(rst), .mode(mode), .depth6(depth6),
    .pclk_div2(pclk_div2), .pclk_inv(pclk_inv), .de_in(de_in), .pix_in(pix_in),
    .out_lanes(out_lanes), .out_de(out_de), .pclk_en(pclk_en)
  );

  // {req[69:66], mode[65:63], d6[62], de[61], pix[60:37], lanes[36:1], de_exp[0]}
  localparam logic [69:0] TBL [9] = '{
    {4'd2,  3'd1, 1'b0, 1'b1, 24'hF03CA5, 36'h0003CF0A5, 1'b1}, // R2
    {4'd3,  3'd1, 1'b1, 1'b1, 24'hF03CA5, 36'h0000F3C29, 1'b1}, // R3
    {4'd2,  3'd5, 1'b0, 1'b1, 24'h7F8001, 36'h000807F01, 1'b1}, // R2
    {4'd3,  3'd2, 1'b1, 1'b1, 24'hFFFFFF, 36'h0003F3F3F, 1'b1}, // R3
    {4'd6,  3'd3, 1'b0, 1'b1, 24'hF0EB10, 36'h000EBF010, 1'b1}, // R6
    {4'd6,  3'd3, 1'b1, 1'b1, 24'hF0EB10, 36'h000EBF010, 1'b1}, // R6
    {4'd8,  3'd6, 1'b0, 1'b1, 24'hFFFFFF, 36'h000000000, 1'b1}, // R8
    {4'd8,  3'd7, 1'b1, 1'b1, 24'hFFFFFF, 36'h000000000, 1'b1}, // R8
    {4'd9,  3'd1, 1'b0, 1'b0, 24'hFFFFFF, 36'h000000000, 1'b0}  // R9, R11
  };

  function automatic logic [17:0] half6(input logic [23:0] p);
    return {p[15:10], p[23:18], p[7:2]};
  endfunction

  function automatic logic [35:0] two_ph(input logic [23:0] o, input logic [23:0] e);
    return {half6(e), half6(o)};
  endfunction

  function automatic logic [35:0] yc422(input logic [23:0] p, input bit cr);
    return {12'h0, p[15:8], (cr ? p[23:16] : p[7:0]), 8'h00};
  endfunction

  task automatic chk(input int req, input string what, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic d6, input logic de, input logic [23:0] p);
    @(negedge clk);
    mode = m; depth6 = d6; de_in = de; pix_in = p;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic e1, e2, e3, e4;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(1, "reset lanes", out_lanes, '0);
    chk(1, "reset de", {35'd0, out_de}, 36'd0);
    chk(1, "reset pclk_en", {35'd0, pclk_en}, 36'd0);
    @(negedge clk);
    rst = 1'b0;

    // table walk: one pixel per row, result one cycle later
    for (int i = 0; i < 9; i++) begin
      drive(TBL[i][65:63], TBL[i][62], TBL[i][61], TBL[i][60:37]);
      chk(int'(TBL[i][69:66]), $sformatf("row %0d lanes", i), out_lanes, TBL[i][36:1]);
      chk(11, $sformatf("row %0d de", i), {35'd0, out_de}, {35'd0, TBL[i][0]});
    end
    chk(10, "undivided enable", {35'd0, pclk_en}, 36'd1); // R10

    // R4: two-phase pairing
    drive(3'd0, 1'b0, 1'b0, 24'h0);
    chk(4, "idle before line", {35'd0, out_de}, 36'd0);
    drive(3'd0, 1'b0, 1'b1, 24'h123456);
    chk(4, "odd held de", {35'd0, out_de}, 36'd0);
    drive(3'd0, 1'b0, 1'b1, 24'hABCDEF);
    chk(4, "pair 1", out_lanes, two_ph(24'h123456, 24'hABCDEF));
    chk(4, "pair 1 de", {35'd0, out_de}, 36'd1);
    drive(3'd0, 1'b0, 1'b1, 24'hFC0840);
    chk(4, "odd held 2", {35'd0, out_de}, 36'd0);
    drive(3'd0, 1'b0, 1'b1, 24'h04FC80);
    chk(4, "pair 2", out_lanes, two_ph(24'hFC0840, 24'h04FC80));
    drive(3'd0, 1'b0, 1'b0, 24'h0);
    chk(5, "even line no flush", {35'd0, out_de}, 36'd0);
    // R5: orphan odd pixel
    drive(3'd0, 1'b0, 1'b1, 24'hC3A5F9);
    chk(5, "orphan held", {35'd0, out_de}, 36'd0);
    drive(3'd0, 1'b0, 1'b0, 24'h0);
    chk(5, "orphan lanes", out_lanes, two_ph(24'hC3A5F9, 24'h0));
    chk(5, "orphan de", {35'd0, out_de}, 36'd1);
    drive(3'd0, 1'b0, 1'b0, 24'h0);
    chk(5, "after orphan", {35'd0, out_de}, 36'd0);

    // R7: 4:2:2 chroma alternation, restarting per line
    drive(3'd4, 1'b0, 1'b0, 24'h0);
    drive(3'd4, 1'b0, 1'b1, 24'h11A022);
    chk(7, "422 px1 Cb", out_lanes, yc422(24'h11A022, 1'b0));
    drive(3'd4, 1'b0, 1'b1, 24'h33B044);
    chk(7, "422 px2 Cr", out_lanes, yc422(24'h33B044, 1'b1));
    drive(3'd4, 1'b0, 1'b1, 24'h55C066);
    chk(7, "422 px3 Cb", out_lanes, yc422(24'h55C066, 1'b0));
    drive(3'd4, 1'b0, 1'b0, 24'h0);
    chk(7, "422 line gap", out_lanes, '0);
    drive(3'd4, 1'b0, 1'b1, 24'h77D088);
    chk(7, "422 new line Cb", out_lanes, yc422(24'h77D088, 1'b0));

    // R10: divided enable and phase step
    @(negedge clk);
    pclk_div2 = 1'b1;
    repeat (2) @(posedge clk);
    #1 e1 = pclk_en;
    @(posedge clk);
    #1 e2 = pclk_en;
    chk(10, "div2 alternates", {35'd0, e2}, {35'd0, ~e1});
    @(negedge clk);
    pclk_inv = 1'b1;
    @(posedge clk);
    #1 e3 = pclk_en;
    chk(10, "inv phase step", {35'd0, e3}, {35'd0, e2});
    @(posedge clk);
    #1 e4 = pclk_en;
    chk(10, "inv alternates", {35'd0, e4}, {35'd0, ~e3});

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule